// File: doc/BRIEF.md
# Multi-Port Storage Host Register File

This block is the register front end of a serial-storage host controller that serves a configurable number of device ports, up to 32. A host processor reaches it through a simple valid/ready register bus of aligned 32-bit words. The address space has two regions. A global region holds the capability word, the global control word, the global interrupt status and the implemented-ports mask. A per-port region gives every port a window of 0x80 bytes for its interrupt status, interrupt enable, command and link-control words. The number of live ports is a runtime input. Only addresses inside the windows of live ports decode as port registers.

Each port collects hardware event bits into its interrupt status. Every live port whose status ANDed with its enable is nonzero sets its bit in the global interrupt status. The host interrupt line is the OR of those bits, gated by the interrupt-enable bit of global control. When software turns on FIS receive in a port's command word, the block pulses a one-cycle request to send that port's initial device-to-host status frame. This happens once per port reset. A global-control write with the reset bit set starts a controller reset. The reset clears the global words at once, then walks the ports one per cycle to clear their interrupt, enable and link-control words and their frame-sent flags.

A small state machine sequences the bus. In ST_IDLE a request is accepted. An accepted read moves it to ST_READ_RSP, where it presents the response for one cycle and then returns to ST_IDLE. An accepted reset write moves it to ST_PORT_RST, where it stays for one cycle per hardware port and returns to ST_IDLE after the last one. Writes other than reset take effect at the accept edge and leave the machine in ST_IDLE.

Top module: `hba_regfile`

## Requirements
- R1: After reset the bus is ready, no response is pending, host_irq and fis_req are low, and global control and global interrupt status both read 0.
- R2: The capability word at 0x000 reads port_count−1 in bits [4:0], NUM_SLOTS−1 in bits [12:8], the value 1 in the speed field [23:20], the AHCI-only flag in bit 18 and the queued-command flag in bit 30. All other bits read 0.
- R3: The implemented-ports word at 0x00C reads (1 << port_count) − 1.
- R4: Port p owns addresses 0x100 + p·0x80 up to 0x17F + p·0x80. Within that window, interrupt status is at offset 0x10, interrupt enable at 0x14, command at 0x18 and link control at 0x2C. A port access decodes only when p < port_count. Other port-region accesses read 0 and their writes change nothing.
- R5: A write to global control at 0x004 with bit 0 clear stores bit 1 as the interrupt enable and sets bit 31 (controller enable). Every other bit reads 0.
- R6: A write to global control with bit 0 set clears global control and global interrupt status at the accept edge. req_ready then stays low for MAX_PORTS cycles while each port's interrupt status, interrupt enable, link control and frame-sent flag are cleared. The command word is kept.
- R7: Port interrupt status is write-1-to-clear and takes event bits from port_evt. Interrupt enable reads back what was written. Global interrupt status at 0x008 is write-1-to-clear, and its bit p is set whenever a live port p has status ANDed with enable nonzero.
- R8: host_irq is high exactly when the interrupt enable of global control is set and global interrupt status is nonzero.
- R9: A command write with bit 4 (FIS receive enable) set, to a port whose frame-sent flag is clear, raises fis_req[p] for exactly one cycle after the accept edge and sets the flag. Further such writes raise nothing until a controller reset.
- R10: An access with either of address bits [1:0] set is ignored. A read returns 0 and a write changes nothing.
- R11: Reads of unmapped addresses in either region return 0, and writes to them change nothing.
- R12: A read accepted at one clock edge presents rsp_valid with its data for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_count | input | PCNT_W | Number of live ports, 1 to MAX_PORTS |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| port_evt | input | MAX_PORTS*32 | Per-port interrupt event bits, port p at [p*32 +: 32] |
| fis_req | output | MAX_PORTS | One-cycle request to send the initial status frame |
| host_irq | output | 1 | Combined host interrupt |

## Verification
A stale frame-sent flag shows at fis_req on the first command write after it goes wrong: either a missing pulse or a second pulse. A stuck per-port or global status bit shows on host_irq within two cycles of the event, and on the next bus read of the global status. A wrong reset-walk counter shows as a busy window of the wrong length on req_ready, or as enable and link-control words that read back nonzero after the walk. Decode faults show on the very next read. The bench sweeps every port count with writes inside and just beyond the live window.

// File: rtl/hba_pkg.sv
package hba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_RSP,
        ST_PORT_RST
    } ctl_state_t;

    typedef enum logic [2:0] {
        G_NONE,
        G_CAP,
        G_CTL,
        G_IS,
        G_PI
    } glb_sel_t;

    typedef enum logic [2:0] {
        P_NONE,
        P_IS,
        P_IE,
        P_CMD,
        P_SCTL
    } prt_sel_t;

    localparam int unsigned PORT_BASE   = 32'h100;
    localparam int unsigned PORT_SHIFT  = 7;
    localparam int          CTL_RST_BIT = 0;
    localparam int          CTL_IE_BIT  = 1;
    localparam int          CMD_FRE_BIT = 4;
endpackage

// File: rtl/hba_addr_decode.sv
module hba_addr_decode
    import hba_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int MAX_PORTS = 4,
    parameter int PCNT_W    = 3,
    parameter int PIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PCNT_W-1:0] port_count,
    output logic              aligned,
    output glb_sel_t          gsel,
    output prt_sel_t          psel,
    output logic              in_port,
    output logic [PIDX_W-1:0] pidx
);
    localparam int SLOT_W = ADDR_W - PORT_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic [SLOT_W-1:0] slot;
    logic [31:0]       slot_ext;
    logic [31:0]       cnt_ext;
    logic              in_glb;

    assign aligned  = (addr[1:0] == 2'b00);
    assign rel      = addr - ADDR_W'(PORT_BASE);
    assign slot     = rel[ADDR_W-1:PORT_SHIFT];
    assign slot_ext = 32'(slot);
    assign cnt_ext  = 32'(port_count);
    assign in_glb   = (32'(addr) < PORT_BASE);
    assign in_port  = aligned && !in_glb && (slot_ext < cnt_ext) &&
                      (slot_ext < 32'(MAX_PORTS));
    assign pidx     = slot[PIDX_W-1:0];

    always_comb begin
        gsel = G_NONE;
        if (aligned && in_glb) begin
            unique case (addr[7:0])
                8'h00:   gsel = G_CAP;
                8'h04:   gsel = G_CTL;
                8'h08:   gsel = G_IS;
                8'h0C:   gsel = G_PI;
                default: gsel = G_NONE;
            endcase
        end
    end

    always_comb begin
        psel = P_NONE;
        if (in_port) begin
            unique case (addr[PORT_SHIFT-1:0])
                7'h10:   psel = P_IS;
                7'h14:   psel = P_IE;
                7'h18:   psel = P_CMD;
                7'h2C:   psel = P_SCTL;
                default: psel = P_NONE;
            endcase
        end
    end
endmodule

// File: rtl/hba_port_regs.sv
module hba_port_regs
    import hba_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_is,
    input  logic        wr_ie,
    input  logic        wr_cmd,
    input  logic        wr_sctl,
    input  logic [31:0] wdata,
    input  logic [31:0] evt,
    output logic [31:0] is_q,
    output logic [31:0] ie_q,
    output logic [31:0] cmd_q,
    output logic [31:0] sctl_q,
    output logic        pending,
    output logic        fis_req
);
    logic sent_q;
    logic fire;

    assign fire    = wr_cmd && wdata[CMD_FRE_BIT] && !sent_q;
    assign pending = |(is_q & ie_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_q    <= '0;
            ie_q    <= '0;
            cmd_q   <= '0;
            sctl_q  <= '0;
            sent_q  <= 1'b0;
            fis_req <= 1'b0;
        end else if (clr) begin
            is_q    <= '0;
            ie_q    <= '0;
            sctl_q  <= '0;
            sent_q  <= 1'b0;
            fis_req <= 1'b0;
        end else begin
            is_q    <= (wr_is ? (is_q & ~wdata) : is_q) | evt;
            if (wr_ie)   ie_q   <= wdata;
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_sctl) sctl_q <= wdata;
            fis_req <= fire;
            if (fire) sent_q <= 1'b1;
        end
    end

    AST_FIS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fis_req |=> !fis_req); // R9
    AST_FIS_MARKS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        fis_req |-> sent_q); // R9
    AST_PORT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (is_q == '0 && ie_q == '0 && sctl_q == '0 && !sent_q)); // R6
endmodule

// File: rtl/hba_ctrl_fsm.sv
module hba_ctrl_fsm
    import hba_pkg::*;
#(
    parameter int MAX_PORTS = 4,
    parameter int PIDX_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_rd,
    input  logic                 acc_rst,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic                 rst_busy,
    output logic [MAX_PORTS-1:0] port_clr
);
    localparam logic [PIDX_W-1:0] LAST = PIDX_W'(MAX_PORTS - 1);

    ctl_state_t        state_q, state_d;
    logic [PIDX_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_rst) begin
                    state_d = ST_PORT_RST;
                    cnt_d   = '0;
                end else if (acc_rd) begin
                    state_d = ST_READ_RSP;
                end
            end
            ST_READ_RSP: state_d = ST_IDLE;
            ST_PORT_RST: begin
                if (cnt_q == LAST) state_d = ST_IDLE;
                else               cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rst_busy  = 1'b0;
        port_clr  = '0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_RSP: rsp_valid = 1'b1;
            ST_PORT_RST: begin
                rst_busy = 1'b1;
                for (int i = 0; i < MAX_PORTS; i++)
                    port_clr[i] = (cnt_q == PIDX_W'(i));
            end
            default: req_ready = 1'b0;
        endcase
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rsp_valid); // R12
    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_ONE_PORT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_clr)); // R6
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile
    import hba_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int MAX_PORTS = 4,
    parameter int NUM_SLOTS = 32,
    parameter int PCNT_W    = $clog2(MAX_PORTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PCNT_W-1:0]      port_count,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    input  logic [MAX_PORTS*32-1:0] port_evt,
    output logic [MAX_PORTS-1:0]   fis_req,
    output logic                   host_irq
);
    localparam int PIDX_W = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1;

    logic              dec_aligned, dec_in_port;
    glb_sel_t          dec_gsel;
    prt_sel_t          dec_psel;
    logic [PIDX_W-1:0] dec_pidx;

    logic acc, acc_wr, acc_rd, acc_rst, rst_busy;
    logic [MAX_PORTS-1:0] port_clr, port_mask, pend;
    logic [MAX_PORTS-1:0] gis_q;
    logic                 ctl_ie_q, ctl_en_q;
    logic [31:0]          cap_w, pi_w, ctl_w, rd_mux, rsp_q;
    logic [31:0]          p_is [MAX_PORTS];
    logic [31:0]          p_ie [MAX_PORTS];
    logic [31:0]          p_cmd [MAX_PORTS];
    logic [31:0]          p_sctl [MAX_PORTS];

    hba_addr_decode #(
        .ADDR_W(ADDR_W), .MAX_PORTS(MAX_PORTS), .PCNT_W(PCNT_W), .PIDX_W(PIDX_W)
    ) u_dec (
        .addr(req_addr), .port_count(port_count), .aligned(dec_aligned),
        .gsel(dec_gsel), .psel(dec_psel), .in_port(dec_in_port), .pidx(dec_pidx)
    );

    assign acc     = req_valid && req_ready;
    assign acc_wr  = acc && req_write;
    assign acc_rd  = acc && !req_write;
    assign acc_rst = acc_wr && (dec_gsel == G_CTL) && req_wdata[CTL_RST_BIT];

    hba_ctrl_fsm #(.MAX_PORTS(MAX_PORTS), .PIDX_W(PIDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_rst(acc_rst),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rst_busy(rst_busy),
        .port_clr(port_clr)
    );

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        logic hit;
        assign hit          = acc_wr && dec_in_port && (dec_pidx == PIDX_W'(p));
        assign port_mask[p] = (32'(port_count) > 32'(p));

        hba_port_regs u_port (
            .clk(clk), .rst_n(rst_n), .clr(port_clr[p]),
            .wr_is(hit && dec_psel == P_IS),
            .wr_ie(hit && dec_psel == P_IE),
            .wr_cmd(hit && dec_psel == P_CMD),
            .wr_sctl(hit && dec_psel == P_SCTL),
            .wdata(req_wdata), .evt(port_evt[p*32 +: 32]),
            .is_q(p_is[p]), .ie_q(p_ie[p]), .cmd_q(p_cmd[p]), .sctl_q(p_sctl[p]),
            .pending(pend[p]), .fis_req(fis_req[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gis_q    <= '0;
            ctl_ie_q <= 1'b0;
            ctl_en_q <= 1'b0;
        end else if (acc_rst || rst_busy) begin
            gis_q <= '0;
            if (acc_rst) begin
                ctl_ie_q <= 1'b0;
                ctl_en_q <= 1'b0;
            end
        end else begin
            gis_q <= ((acc_wr && dec_gsel == G_IS) ?
                      (gis_q & ~req_wdata[MAX_PORTS-1:0]) : gis_q) |
                     (pend & port_mask);
            if (acc_wr && dec_gsel == G_CTL) begin
                ctl_ie_q <= req_wdata[CTL_IE_BIT];
                ctl_en_q <= 1'b1;
            end
        end
    end

    assign host_irq = ctl_ie_q && (gis_q != '0);

    always_comb begin
        cap_w        = '0;
        cap_w[4:0]   = 5'(port_count - 1'b1);
        cap_w[12:8]  = 5'(NUM_SLOTS - 1);
        cap_w[18]    = 1'b1;
        cap_w[23:20] = 4'd1;
        cap_w[30]    = 1'b1;
        pi_w         = 32'(port_mask);
        ctl_w        = {ctl_en_q, 29'd0, ctl_ie_q, 1'b0};
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec_gsel)
            G_CAP:   rd_mux = cap_w;
            G_CTL:   rd_mux = ctl_w;
            G_IS:    rd_mux = 32'(gis_q);
            G_PI:    rd_mux = pi_w;
            default: rd_mux = '0;
        endcase
        if (dec_in_port) begin
            unique case (dec_psel)
                P_IS:    rd_mux = p_is[dec_pidx];
                P_IE:    rd_mux = p_ie[dec_pidx];
                P_CMD:   rd_mux = p_cmd[dec_pidx];
                P_SCTL:  rd_mux = p_sctl[dec_pidx];
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_q <= '0;
        else if (acc_rd) rsp_q <= rd_mux;
    end

    assign rsp_rdata = rsp_q;

    AST_CTL_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_rst) |-> (gis_q == '0 && !ctl_ie_q && !ctl_en_q)); // R6
    AST_MISALIGNED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_wr && !dec_aligned) |->
            (ctl_ie_q == $past(ctl_ie_q) && ctl_en_q == $past(ctl_en_q))); // R10
    AST_NO_ACCEPT_WHILE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rst |=> !req_ready); // R6
endmodule

// File: tb/tb_hba_regfile.sv
module tb_hba_regfile;
    localparam int MAXP   = 4;
    localparam int ADDR_W = 13;
    localparam int PCW    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PCW-1:0]    port_count = 3'd4;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [MAXP*32-1:0] port_evt = '0;
    logic [MAXP-1:0]   fis_req;
    logic              host_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_ie [MAXP+1];

    always #2 clk = ~clk;

    hba_regfile #(.ADDR_W(ADDR_W), .MAX_PORTS(MAXP), .NUM_SLOTS(32)) dut (
        .clk(clk), .rst_n(rst_n), .port_count(port_count),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .port_evt(port_evt), .fis_req(fis_req),
        .host_irq(host_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                          input string req);
        logic [31:0] v;
        do_read(a, v);
        chk(v == exp, req, v, exp);
    endtask

    function automatic logic [ADDR_W-1:0] paddr(input int p, input int off);
        return ADDR_W'(32'h100 + p * 32'h80 + off);
    endfunction

    task automatic pulse_evt(input int p, input logic [31:0] bits);
        @(negedge clk);
        port_evt[p*32 +: 32] = bits;
        @(negedge clk);
        port_evt = '0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int busy;
        for (int i = 0; i <= MAXP; i++) model_ie[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk(host_irq == 1'b0, "R1 irq", 32'(host_irq), 32'd0);
        chk(fis_req == '0, "R1 fis_req", 32'(fis_req), 32'd0);
        rd_chk(13'h004, 32'h0, "R1 ctl");
        rd_chk(13'h008, 32'h0, "R1 gis");

        // R12 read latency and single beat
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h00C;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R12 valid", 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == 32'hF, "R12 data", rsp_rdata, 32'hF);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 single", 32'(rsp_valid), 32'd0);

        // R2 R3 R4 sweep over every port count
        for (int pc = 1; pc <= MAXP; pc++) begin
            port_count = PCW'(pc);
            rd_chk(13'h000, 32'(pc - 1) | (32'd31 << 8) | (32'd1 << 18) |
                   (32'd1 << 20) | (32'd1 << 30), "R2 cap");
            rd_chk(13'h00C, (32'd1 << pc) - 1, "R3 pi");
            for (int p = 0; p <= MAXP; p++) begin
                do_write(paddr(p, 'h14), 32'hA500_0000 | 32'(pc << 8) | 32'(p));
                if (p < pc) model_ie[p] = 32'hA500_0000 | 32'(pc << 8) | 32'(p);
            end
            for (int p = 0; p <= MAXP; p++)
                rd_chk(paddr(p, 'h14), (p < pc) ? model_ie[p] : 32'h0, "R4 window");
        end
        for (int p = 0; p < MAXP; p++)
            rd_chk(paddr(p, 'h14), model_ie[p], "R4 ignored writes");

        // R5 global control
        do_write(13'h004, 32'h2);
        rd_chk(13'h004, 32'h8000_0002, "R5 ie set");
        do_write(13'h004, 32'hFFFF_FFFE);
        rd_chk(13'h004, 32'h8000_0002, "R5 mask");
        do_write(13'h004, 32'h0);
        rd_chk(13'h004, 32'h8000_0000, "R5 en forced");

        // R10 misaligned
        for (int k = 1; k < 4; k++) begin
            do_write(ADDR_W'(4 + k), 32'h2);
            rd_chk(13'h004, 32'h8000_0000, "R10 write ignored");
            rd_chk(ADDR_W'(4 + k), 32'h0, "R10 read zero");
        end
        do_write(paddr(0, 'h16), 32'h1234_5678);
        rd_chk(paddr(0, 'h14), model_ie[0], "R10 port write ignored");

        // R11 unmapped
        rd_chk(13'h010, 32'h0, "R11 glb 0x10");
        rd_chk(13'h0FC, 32'h0, "R11 glb 0xFC");
        rd_chk(paddr(1, 'h00), 32'h0, "R11 port off 0");
        rd_chk(paddr(1, 'h7C), 32'h0, "R11 port off 7C");
        do_write(13'h010, 32'hFFFF_FFFF);
        do_write(paddr(1, 'h7C), 32'hFFFF_FFFF);
        rd_chk(13'h004, 32'h8000_0000, "R11 ctl kept");
        rd_chk(13'h008, 32'h0, "R11 gis kept");
        rd_chk(paddr(1, 'h14), model_ie[1], "R11 ie kept");

        // R7 R8 interrupts per port
        for (int p = 0; p < MAXP; p++) do_write(paddr(p, 'h14), 32'h1);
        do_write(13'h004, 32'h2);
        for (int p = 0; p < MAXP; p++) begin
            pulse_evt(p, 32'h1);
            chk(host_irq == 1'b1, "R8 irq on", 32'(host_irq), 32'd1);
            rd_chk(13'h008, 32'd1 << p, "R7 gis bit");
            rd_chk(paddr(p, 'h10), 32'h1, "R7 port is");
            do_write(paddr(p, 'h10), 32'h1);
            do_write(13'h008, 32'd1 << p);
            rd_chk(13'h008, 32'h0, "R7 gis w1c");
            chk(host_irq == 1'b0, "R8 irq off", 32'(host_irq), 32'd0);
        end
        pulse_evt(2, 32'h2);
        chk(host_irq == 1'b0, "R7 masked event", 32'(host_irq), 32'd0);
        rd_chk(paddr(2, 'h10), 32'h2, "R7 masked is");
        rd_chk(13'h008, 32'h0, "R7 masked gis");
        do_write(paddr(2, 'h10), 32'h2);
        do_write(13'h004, 32'h0);
        pulse_evt(0, 32'h1);
        chk(host_irq == 1'b0, "R8 gated", 32'(host_irq), 32'd0);
        rd_chk(13'h008, 32'h1, "R8 gis while gated");
        do_write(13'h004, 32'h2);
        chk(host_irq == 1'b1, "R8 ungated", 32'(host_irq), 32'd1);
        do_write(paddr(0, 'h10), 32'h1);
        do_write(13'h008, 32'h1);
        port_count = 3'd2;
        pulse_evt(3, 32'h1);
        rd_chk(13'h008, 32'h0, "R7 dead port");
        chk(host_irq == 1'b0, "R8 dead port", 32'(host_irq), 32'd0);
        port_count = 3'd4;
        do_write(paddr(3, 'h10), 32'h1);
        do_write(13'h008, 32'h8);
        rd_chk(13'h008, 32'h0, "R7 cleanup");

        // R9 initial frame request
        for (int p = 0; p < MAXP; p++) begin
            do_write(paddr(p, 'h18), 32'h0);
            chk(fis_req == '0, "R9 no FRE", 32'(fis_req), 32'd0);
            do_write(paddr(p, 'h18), 32'h10);
            chk(fis_req == (MAXP'(1) << p), "R9 pulse", 32'(fis_req), 32'd1 << p);
            @(negedge clk);
            chk(fis_req == '0, "R9 one cycle", 32'(fis_req), 32'd0);
            do_write(paddr(p, 'h18), 32'h10);
            chk(fis_req == '0, "R9 once", 32'(fis_req), 32'd0);
        end

        // R6 controller reset
        do_write(paddr(1, 'h2C), 32'h0000_0301);
        do_write(paddr(1, 'h14), 32'h1);
        pulse_evt(1, 32'h1);
        chk(host_irq == 1'b1, "R6 pre irq", 32'(host_irq), 32'd1);
        do_write(13'h004, 32'h1);
        busy = 0;
        while (!req_ready && busy < 100) begin
            busy++;
            @(negedge clk);
        end
        chk(busy == MAXP, "R6 walk length", 32'(busy), 32'(MAXP));
        chk(host_irq == 1'b0, "R6 irq cleared", 32'(host_irq), 32'd0);
        rd_chk(13'h004, 32'h0, "R6 ctl");
        rd_chk(13'h008, 32'h0, "R6 gis");
        for (int p = 0; p < MAXP; p++) begin
            rd_chk(paddr(p, 'h10), 32'h0, "R6 is");
            rd_chk(paddr(p, 'h14), 32'h0, "R6 ie");
            rd_chk(paddr(p, 'h2C), 32'h0, "R6 sctl");
            rd_chk(paddr(p, 'h18), 32'h10, "R6 cmd kept");
        end
        do_write(paddr(2, 'h18), 32'h10);
        chk(fis_req == 4'b0100, "R9 after reset", 32'(fis_req), 32'h4);

        do_read(13'h000, v);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule